// File: doc/BRIEF.md
# Single-master local memory bus interconnect

This block is the interconnect of a tightly coupled memory bus that has exactly one master, the processor's instruction or data port, and a configurable number of slaves, usually on-chip RAM controllers. The master's address, read, write and address strobes, byte enables and write data are sent to every slave at once. The block adds no register on this path, so one access can be issued on every clock cycle. Each slave decodes its own address range. No arbiter is needed because only one master can start an access.

On the way back, every slave drives its read data, ready, wait, uncorrectable-error and correctable-error signals. The block merges these into one response for the master. An idle or unselected slave must drive all of its response signals to zero, so the merge is a bitwise OR across the slaves.

The block also turns an external system reset into the bus reset. A parameter sets whether the external reset is active-high or active-low. The bus reset output is always active-high and is registered on the bus clock. The whole block runs on a single bus clock, which must be the processor clock.

Top module: `lmem_fabric`

## Requirements
- R1: The address, read strobe, write strobe, address strobe, byte enables (one per byte lane, bit i covering data bits 8i+7..8i) and write data appear on the bus outputs in the same cycle as on the master inputs, with no added register. A new value is passed on every cycle.
- R2: The merged read data is the bitwise OR of all slave read data words. Slave k supplies bits k*32+31..k*32 of the packed slave data input.
- R3: The merged ready is high exactly when at least one slave's ready bit is high. Slave k uses bit k of each per-slave flag vector.
- R4: The merged wait is high exactly when at least one slave's wait bit is high.
- R5: The merged uncorrectable-error flag and the merged correctable-error flag are each the OR of the matching slave bits. A slave that raises ready together with an error flag makes both outputs high in the same cycle.
- R6: With RST_ACTIVE_HIGH=1 the external reset is asserted when it is 1. With RST_ACTIVE_HIGH=0 it is asserted when it is 0.
- R7: The bus reset output is a register. It goes high at the first clock edge that samples the external reset asserted. It goes low at the first clock edge that samples it released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, the same as the processor clock |
| sys_rst_i | input | 1 | External system reset, polarity set by RST_ACTIVE_HIGH |
| bus_rst_o | output | 1 | Registered active-high bus reset |
| mst_addr_i | input | ADDR_W | Master address |
| mst_rd_stb_i | input | 1 | Master read strobe |
| mst_wr_stb_i | input | 1 | Master write strobe |
| mst_as_i | input | 1 | Master address strobe |
| mst_wdata_i | input | DATA_W | Master write data |
| mst_be_i | input | DATA_W/8 | Master byte enables |
| slv_rdata_i | input | NUM_SLV*DATA_W | Packed slave read data, slave k in word k |
| slv_ready_i | input | NUM_SLV | Per-slave ready |
| slv_wait_i | input | NUM_SLV | Per-slave wait |
| slv_ue_i | input | NUM_SLV | Per-slave uncorrectable error |
| slv_ce_i | input | NUM_SLV | Per-slave correctable error |
| bus_addr_o | output | ADDR_W | Address to all slaves |
| bus_rd_stb_o | output | 1 | Read strobe to all slaves |
| bus_wr_stb_o | output | 1 | Write strobe to all slaves |
| bus_as_o | output | 1 | Address strobe to all slaves |
| bus_rdata_o | output | DATA_W | Merged read data to the master |
| bus_wdata_o | output | DATA_W | Write data to all slaves |
| bus_ready_o | output | 1 | Merged ready |
| bus_wait_o | output | 1 | Merged wait |
| bus_ue_o | output | 1 | Merged uncorrectable error |
| bus_ce_o | output | 1 | Merged correctable error |
| bus_be_o | output | DATA_W/8 | Byte enables to all slaves |

## Verification
The bench drives one slave at a time in every position, with the read data of the others held at zero. A merge that drops the last slave, or slices a wrong word out of the packed vector, then returns zero or the wrong word. A slave that raises ready and an uncorrectable error in the same cycle, while another slave raises a correctable error, catches a merge that lets one flag win over another or delays an error flag. Reset pulses are applied to one instance of each polarity. An inverted polarity, or a bus reset that is combinational or two stages deep, shows up as a bus reset in the wrong cycle. Back-to-back random accesses catch any register added on the request path.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

    localparam int unsigned LM_DATA_W  = 32;
    localparam int unsigned LM_BE_W    = LM_DATA_W / 8;
    localparam int unsigned LM_MAX_SLV = 16;
    localparam int unsigned LM_MIN_AW  = 32;
    localparam int unsigned LM_MAX_AW  = 64;

    typedef logic [LM_DATA_W-1:0] word_t;
    typedef logic [LM_BE_W-1:0]   lane_t;

    // request fields that do not depend on the address width
    typedef struct packed {
        logic  rd;
        logic  wr;
        logic  as;
        lane_t be;
        word_t wdata;
    } req_ctl_t;

    // one slave's response, also the merged response
    typedef struct packed {
        word_t rdata;
        logic  ready;
        logic  stall;
        logic  ue;
        logic  ce;
    } rsp_t;

    localparam rsp_t RSP_IDLE = '{rdata: '0, ready: 1'b0, stall: 1'b0, ue: 1'b0, ce: 1'b0};

    function automatic rsp_t rsp_or(rsp_t a, rsp_t b);
        rsp_t r;
        r.rdata = a.rdata | b.rdata;
        r.ready = a.ready | b.ready;
        r.stall = a.stall | b.stall;
        r.ue    = a.ue    | b.ue;
        r.ce    = a.ce    | b.ce;
        return r;
    endfunction

endpackage

// File: rtl/lmem_req_fanout.sv
module lmem_req_fanout
    import lmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  req_ctl_t          ctl_i,
    output logic [ADDR_W-1:0] addr_o,
    output req_ctl_t          ctl_o
);
    // Single master: no arbitration, the request is broadcast unregistered.
    assign addr_o = addr_i;
    assign ctl_o  = ctl_i;
endmodule

// File: rtl/lmem_rsp_merge.sv
module lmem_rsp_merge
    import lmem_pkg::*;
#(
    parameter int unsigned NUM_SLV = 4
) (
    input  rsp_t [NUM_SLV-1:0] slv_rsp_i,
    output rsp_t               merged_o
);
    // Idle slaves drive zero, so an OR reduction is the whole merge.
    always_comb begin
        merged_o = RSP_IDLE;
        for (int k = 0; k < NUM_SLV; k++) begin
            merged_o = rsp_or(merged_o, slv_rsp_i[k]);
        end
    end
endmodule

// File: rtl/lmem_rst_cond.sv
module lmem_rst_cond #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic ext_rst_i,
    output logic rst_level_o,
    output logic bus_rst_o
);
    localparam logic ASSERT_LVL = ACTIVE_HIGH;

    logic bus_rst_q;

    assign rst_level_o = (ext_rst_i == ASSERT_LVL);

    always_ff @(posedge clk) begin
        bus_rst_q <= rst_level_o;
    end

    assign bus_rst_o = bus_rst_q;

    assert_rst_rise_R6: assert property (@(posedge clk)
        (ext_rst_i == ASSERT_LVL) |=> bus_rst_o)
        else $error("bus reset not raised after external reset at its active level");

    assert_rst_fall_R7: assert property (@(posedge clk)
        (ext_rst_i != ASSERT_LVL) |=> !bus_rst_o)
        else $error("bus reset still high one edge after release");
endmodule

// File: rtl/lmem_fabric.sv
module lmem_fabric
    import lmem_pkg::*;
#(
    parameter int unsigned NUM_SLV         = 4,
    parameter int unsigned ADDR_W          = 32,
    parameter int unsigned DATA_W          = LM_DATA_W,
    parameter bit          RST_ACTIVE_HIGH = 1'b1,
    localparam int unsigned BE_W           = DATA_W / 8
) (
    input  logic                      clk,
    input  logic                      sys_rst_i,
    output logic                      bus_rst_o,
    input  logic [ADDR_W-1:0]         mst_addr_i,
    input  logic                      mst_rd_stb_i,
    input  logic                      mst_wr_stb_i,
    input  logic                      mst_as_i,
    input  logic [DATA_W-1:0]         mst_wdata_i,
    input  logic [BE_W-1:0]           mst_be_i,
    input  logic [NUM_SLV*DATA_W-1:0] slv_rdata_i,
    input  logic [NUM_SLV-1:0]        slv_ready_i,
    input  logic [NUM_SLV-1:0]        slv_wait_i,
    input  logic [NUM_SLV-1:0]        slv_ue_i,
    input  logic [NUM_SLV-1:0]        slv_ce_i,
    output logic [ADDR_W-1:0]         bus_addr_o,
    output logic                      bus_rd_stb_o,
    output logic                      bus_wr_stb_o,
    output logic                      bus_as_o,
    output logic [DATA_W-1:0]         bus_rdata_o,
    output logic [DATA_W-1:0]         bus_wdata_o,
    output logic                      bus_ready_o,
    output logic                      bus_wait_o,
    output logic                      bus_ue_o,
    output logic                      bus_ce_o,
    output logic [BE_W-1:0]           bus_be_o
);
    // ---------------- parameter checks ----------------
    if (NUM_SLV < 1 || NUM_SLV > LM_MAX_SLV) begin : g_bad_slv
        $error("NUM_SLV must lie in 1..16");
    end
    if (ADDR_W < LM_MIN_AW || ADDR_W > LM_MAX_AW) begin : g_bad_aw
        $error("ADDR_W must lie in 32..64");
    end
    if (DATA_W != LM_DATA_W) begin : g_bad_dw
        $error("DATA_W is fixed at 32");
    end

    // ---------------- reset conditioning ----------------
    logic rst_level;

    lmem_rst_cond #(
        .ACTIVE_HIGH (RST_ACTIVE_HIGH)
    ) u_rst (
        .clk         (clk),
        .ext_rst_i   (sys_rst_i),
        .rst_level_o (rst_level),
        .bus_rst_o   (bus_rst_o)
    );

    // ---------------- request broadcast ----------------
    req_ctl_t ctl_in, ctl_out;

    assign ctl_in = '{rd: mst_rd_stb_i, wr: mst_wr_stb_i, as: mst_as_i,
                      be: mst_be_i, wdata: mst_wdata_i};

    lmem_req_fanout #(
        .ADDR_W (ADDR_W)
    ) u_fanout (
        .addr_i (mst_addr_i),
        .ctl_i  (ctl_in),
        .addr_o (bus_addr_o),
        .ctl_o  (ctl_out)
    );

    assign bus_rd_stb_o = ctl_out.rd;
    assign bus_wr_stb_o = ctl_out.wr;
    assign bus_as_o     = ctl_out.as;
    assign bus_be_o     = ctl_out.be;
    assign bus_wdata_o  = ctl_out.wdata;

    // ---------------- response merge ----------------
    rsp_t [NUM_SLV-1:0] slv_rsp;
    rsp_t               merged;

    always_comb begin
        for (int k = 0; k < NUM_SLV; k++) begin
            slv_rsp[k].rdata = slv_rdata_i[k*DATA_W +: DATA_W];
            slv_rsp[k].ready = slv_ready_i[k];
            slv_rsp[k].stall = slv_wait_i[k];
            slv_rsp[k].ue    = slv_ue_i[k];
            slv_rsp[k].ce    = slv_ce_i[k];
        end
    end

    lmem_rsp_merge #(
        .NUM_SLV (NUM_SLV)
    ) u_merge (
        .slv_rsp_i (slv_rsp),
        .merged_o  (merged)
    );

    assign bus_rdata_o = merged.rdata;
    assign bus_ready_o = merged.ready;
    assign bus_wait_o  = merged.stall;
    assign bus_ue_o    = merged.ue;
    assign bus_ce_o    = merged.ce;

    // ---------------- assertions ----------------
    assert_strobe_pass_R1: assert property (@(posedge clk) disable iff (rst_level)
        (mst_as_i && mst_wr_stb_i) |-> (bus_as_o && bus_wr_stb_o))
        else $error("write access not broadcast in the same cycle");

    assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (rst_level)
        (slv_rdata_i == '0) |-> (bus_rdata_o == '0))
        else $error("read data nonzero while every slave drives zero");

    assert_ready_any_R3: assert property (@(posedge clk) disable iff (rst_level)
        $onehot(slv_ready_i) |-> bus_ready_o)
        else $error("single slave ready lost in merge");

    assert_wait_idle_R4: assert property (@(posedge clk) disable iff (rst_level)
        (slv_wait_i == '0) |-> !bus_wait_o)
        else $error("wait raised with no slave waiting");

    assert_ready_err_R5: assert property (@(posedge clk) disable iff (rst_level)
        ((slv_ready_i & slv_ue_i) != '0) |-> (bus_ready_o && bus_ue_o))
        else $error("ready and uncorrectable error not passed together");
endmodule

// File: tb/test_lmem_fabric.sv
`timescale 1ns/1ps
module test_lmem_fabric;
    localparam int NS = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              sys_rst_hi, sys_rst_lo;
    logic [AW-1:0]     m_addr;
    logic              m_rd, m_wr, m_as;
    logic [DW-1:0]     m_wdata;
    logic [BW-1:0]     m_be;
    logic [NS*DW-1:0]  s_rdata;
    logic [NS-1:0]     s_ready, s_wait, s_ue, s_ce;

    logic              b_rst;
    logic [AW-1:0]     b_addr;
    logic              b_rd, b_wr, b_as, b_ready, b_wait, b_ue, b_ce;
    logic [DW-1:0]     b_rdata, b_wdata;
    logic [BW-1:0]     b_be;

    logic              n_rst;
    logic [AW-1:0]     n_addr;
    logic              n_rd, n_wr, n_as, n_ready, n_wait, n_ue, n_ce;
    logic [DW-1:0]     n_rdata, n_wdata;
    logic [BW-1:0]     n_be;

    lmem_fabric #(.NUM_SLV(NS), .ADDR_W(AW), .RST_ACTIVE_HIGH(1'b1)) i_lmem_fabric (
        .clk(clk), .sys_rst_i(sys_rst_hi), .bus_rst_o(b_rst),
        .mst_addr_i(m_addr), .mst_rd_stb_i(m_rd), .mst_wr_stb_i(m_wr), .mst_as_i(m_as),
        .mst_wdata_i(m_wdata), .mst_be_i(m_be),
        .slv_rdata_i(s_rdata), .slv_ready_i(s_ready), .slv_wait_i(s_wait),
        .slv_ue_i(s_ue), .slv_ce_i(s_ce),
        .bus_addr_o(b_addr), .bus_rd_stb_o(b_rd), .bus_wr_stb_o(b_wr), .bus_as_o(b_as),
        .bus_rdata_o(b_rdata), .bus_wdata_o(b_wdata), .bus_ready_o(b_ready),
        .bus_wait_o(b_wait), .bus_ue_o(b_ue), .bus_ce_o(b_ce), .bus_be_o(b_be));

    lmem_fabric #(.NUM_SLV(NS), .ADDR_W(AW), .RST_ACTIVE_HIGH(1'b0)) i_lmem_fabric_n (
        .clk(clk), .sys_rst_i(sys_rst_lo), .bus_rst_o(n_rst),
        .mst_addr_i(m_addr), .mst_rd_stb_i(m_rd), .mst_wr_stb_i(m_wr), .mst_as_i(m_as),
        .mst_wdata_i(m_wdata), .mst_be_i(m_be),
        .slv_rdata_i(s_rdata), .slv_ready_i(s_ready), .slv_wait_i(s_wait),
        .slv_ue_i(s_ue), .slv_ce_i(s_ce),
        .bus_addr_o(n_addr), .bus_rd_stb_o(n_rd), .bus_wr_stb_o(n_wr), .bus_as_o(n_as),
        .bus_rdata_o(n_rdata), .bus_wdata_o(n_wdata), .bus_ready_o(n_ready),
        .bus_wait_o(n_wait), .bus_ue_o(n_ue), .bus_ce_o(n_ce), .bus_be_o(n_be));

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    bit seen_edge = 1'b0;

    // reference reset model: what each bus reset should hold after the latest edge
    bit exp_rst_hi, exp_rst_lo;
    always @(posedge clk) begin
        exp_rst_hi <= (sys_rst_hi == 1'b1);
        exp_rst_lo <= (sys_rst_lo == 1'b0);
        seen_edge  <= 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // behavioural reference, compared on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            logic [DW-1:0] e_rdata;
            bit e_ready, e_wait, e_ue, e_ce;
            e_rdata = '0; e_ready = 0; e_wait = 0; e_ue = 0; e_ce = 0;
            for (int k = 0; k < NS; k++) begin
                e_rdata = e_rdata | s_rdata[k*DW +: DW];
                if (s_ready[k]) e_ready = 1;
                if (s_wait[k])  e_wait  = 1;
                if (s_ue[k])    e_ue    = 1;
                if (s_ce[k])    e_ce    = 1;
            end
            chk("R1 addr",  64'(b_addr),  64'(m_addr));
            chk("R1 strobes", {61'd0, b_rd, b_wr, b_as}, {61'd0, m_rd, m_wr, m_as});
            chk("R1 be",    64'(b_be),    64'(m_be));
            chk("R1 wdata", 64'(b_wdata), 64'(m_wdata));
            chk("R2 rdata", 64'(b_rdata), 64'(e_rdata));
            chk("R3 ready", 64'(b_ready), 64'(e_ready));
            chk("R4 wait",  64'(b_wait),  64'(e_wait));
            chk("R5 ue",    64'(b_ue),    64'(e_ue));
            chk("R5 ce",    64'(b_ce),    64'(e_ce));
            chk("R6 low-active instance rdata", 64'(n_rdata), 64'(e_rdata));
            if (seen_edge) begin
                chk("R7 bus reset (high-active ext)", 64'(b_rst), 64'(exp_rst_hi));
                chk("R6 bus reset (low-active ext)",  64'(n_rst), 64'(exp_rst_lo));
            end
        end
    end

    task automatic idle_slaves();
        s_rdata = '0; s_ready = '0; s_wait = '0; s_ue = '0; s_ce = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        sys_rst_hi = 1'b1; sys_rst_lo = 1'b0;
        m_addr = '0; m_rd = 0; m_wr = 0; m_as = 0; m_wdata = '0; m_be = '0;
        idle_slaves();
        // reset state, R7/R6: both bus resets high while held
        repeat (3) step();
        sys_rst_hi = 1'b0; sys_rst_lo = 1'b1;
        step();
        // all idle: R2 zero data, R3..R5 low
        step();
        // each slave alone returns its word (R2) with ready (R3)
        for (int k = 0; k < NS; k++) begin
            idle_slaves();
            m_addr = 32'h1000_0000 + 32'(k * 4); m_as = 1; m_rd = 1; m_be = 4'hF;
            s_rdata[k*DW +: DW] = 32'hA5C3_0000 + 32'(k);
            s_ready[k] = 1'b1;
            step();
        end
        // R5: ready and uncorrectable error from slave 2, correctable error from slave 0
        idle_slaves();
        s_ready[2] = 1; s_ue[2] = 1; s_ce[0] = 1;
        s_rdata[2*DW +: DW] = 32'hDEAD_BEEF;
        step();
        // R4: wait from the last slave only, then all slaves
        idle_slaves();
        s_wait[NS-1] = 1;
        step();
        s_wait = '1; s_ready = '1;
        step();
        // R1: back-to-back writes, distinct each cycle
        idle_slaves();
        m_rd = 0;
        for (int i = 0; i < 6; i++) begin
            m_as = 1; m_wr = 1; m_addr = 32'hFFFF_FFF0 - 32'(i * 4);
            m_wdata = 32'h0101_0101 * 32'(i + 1); m_be = 4'(1 << (i % 4));
            step();
        end
        // R7/R6: single-cycle reset pulses on each polarity
        sys_rst_hi = 1; step(); sys_rst_hi = 0; step(); step();
        sys_rst_lo = 0; step(); sys_rst_lo = 1; step(); step();
        // random traffic with occasional resets
        for (int i = 0; i < 400; i++) begin
            m_addr  = $urandom; m_wdata = $urandom; m_be = 4'($urandom);
            m_rd = 1'($urandom); m_wr = 1'($urandom); m_as = 1'($urandom);
            for (int k = 0; k < NS; k++) s_rdata[k*DW +: DW] = ($urandom % 3 == 0) ? $urandom : 32'd0;
            s_ready = NS'($urandom); s_wait = NS'($urandom);
            s_ue = NS'($urandom); s_ce = NS'($urandom);
            sys_rst_hi = ($urandom % 16 == 0);
            sys_rst_lo = ($urandom % 16 != 0);
            step();
        end
        step();
        finish_run();
    end
endmodule